// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Decay Modes

This block turns the abstract drive request for one winding into the four gate commands of a full bridge: the high-side and low-side switches of leg 1 and of leg 2. Upstream logic supplies the winding polarity, a phase-enable from the step sequencer, an off-time request from the current chopper, a decay-mode select and a global enable. From these the block computes the wanted gate pattern. It moves the bridge from the present pattern to the wanted one so that no leg ever shorts the supply, and so that no switch turns on before a programmable dead time has passed since the last switch turned off.

During an off-time the bridge recirculates current in one of two ways. In fast decay both conducting switches open, and after the dead time only the low side of the other leg closes. That low-side switch gives quasi-synchronous rectification and cannot let the current reverse. In slow decay only the conducting low-side switch opens, and the conducting high-side switch stays closed without a break. After the dead time the other high side closes, so the winding current loops through the upper half of the bridge. The global enable clears all four gates in the same cycle, without waiting for a clock edge. All ports are plain control pins. The block carries no data stream, so it has no valid/ready handshake.

Top module: `hbridge_gate_seq`

## Requirements
- R1: The high-side and low-side gates of the same leg are never high together (hi1 with lo1, hi2 with lo2).
- R2: When a clock edge turns any gate off, or sees the global enable low, no gate turns on at the following DT_CYC-1 edges. Gates still waiting turn on at the DT_CYC-th edge, if the wanted pattern is unchanged. Gates that stay in the wanted pattern are never interrupted.
- R3: With phase-enable high and no off-request, the on pattern is hi1+lo2 when dir_i=1 and hi2+lo1 when dir_i=0 (bench vector order {hi1,lo1,hi2,lo2}: 4'b1001 and 4'b0110).
- R4: In fast decay (slow_i=0, chop_off_i=1), both conducting gates drop at the first edge. After the dead time only lo1 (dir_i=1, 4'b0100) or lo2 (dir_i=0, 4'b0001) is on. No high-side gate is on.
- R5: In slow decay (slow_i=1, chop_off_i=1), the conducting low side drops at the first edge and the conducting high side stays on. After the dead time both high sides are on (4'b1010) and no low-side gate is on.
- R6: When chop_off_i falls, the on pattern of R3 comes back under the dead-time rule of R2.
- R7: While en_i is low all four outputs are low in the same cycle, with no clock edge needed. After en_i rises, the dead time of R2 applies before any gate turns on.
- R8: A change of dir_i while driving turns every gate off. The new diagonal is driven after the dead time.
- R9: While ph_en_i is low, all gates are off from the next edge on, whatever chop_off_i and slow_i are.
- R10: During reset all gates are off. The first turn-on comes at the DT_CYC-th edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low forces all gates off at once |
| ph_en_i | input | 1 | Phase-enable from the step sequencer |
| dir_i | input | 1 | Winding polarity (1: leg 1 high, leg 2 low) |
| chop_off_i | input | 1 | Off-time request from the current chopper |
| slow_i | input | 1 | Decay select (1: slow, 0: fast) |
| g_hi1_o | output | 1 | Leg 1 high-side gate |
| g_lo1_o | output | 1 | Leg 1 low-side gate |
| g_hi2_o | output | 1 | Leg 2 high-side gate |
| g_lo2_o | output | 1 | Leg 2 low-side gate |

## Verification
Two functions can meet in one cycle: the dead-time wait after a turn-off, and a new target change such as an off-request or a polarity flip. The bench provokes this in two ways. It pulses chop_off_i for fewer cycles than the dead time, and it flips dir_i on the same edge that chop_off_i rises. A behavioural model counts the edges since the last turn-off and predicts all four gates. Its prediction is compared with the outputs every cycle. The model judges whether the late request restarts the wait and whether a gate common to the old and new patterns keeps running without a break.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  localparam int unsigned GATES = 4;
  localparam int unsigned HI1 = 0;
  localparam int unsigned LO1 = 1;
  localparam int unsigned HI2 = 2;
  localparam int unsigned LO2 = 3;
  typedef logic [GATES-1:0] gate_vec_t;
endpackage

// File: rtl/hbg_pattern.sv
module hbg_pattern
  import hbg_pkg::*;
(
  input  logic      ph_en_i,
  input  logic      dir_i,
  input  logic      chop_off_i,
  input  logic      slow_i,
  output gate_vec_t want_o
);
  always_comb begin
    want_o = '0;
    if (ph_en_i) begin
      if (!chop_off_i) begin
        if (dir_i) begin
          want_o[HI1] = 1'b1;
          want_o[LO2] = 1'b1;
        end else begin
          want_o[HI2] = 1'b1;
          want_o[LO1] = 1'b1;
        end
      end else if (slow_i) begin
        want_o[HI1] = 1'b1;
        want_o[HI2] = 1'b1;
      end else if (dir_i) begin
        want_o[LO1] = 1'b1;
      end else begin
        want_o[LO2] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime #(
  parameter int unsigned DT_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload_i,
  output logic ready_o
);
  localparam int unsigned CW = (DT_CYC < 2) ? 1 : $clog2(DT_CYC);
  localparam logic [CW-1:0] LOAD = CW'(DT_CYC - 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= LOAD;
    else if (reload_i) wait_q <= LOAD;
    else if (wait_q != '0) wait_q <= wait_q - 1'b1;
  end

  assign ready_o = (wait_q == '0);
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int unsigned DT_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ph_en_i,
  input  logic dir_i,
  input  logic chop_off_i,
  input  logic slow_i,
  output logic g_hi1_o,
  output logic g_lo1_o,
  output logic g_hi2_o,
  output logic g_lo2_o
);
  localparam int unsigned AW = $clog2(DT_CYC + 1);

  gate_vec_t want, gate_q, gate_nx, gate_out;
  logic      any_drop, any_add, reload, dt_ready;

  hbg_pattern u_pattern (
    .ph_en_i    (ph_en_i),
    .dir_i      (dir_i),
    .chop_off_i (chop_off_i),
    .slow_i     (slow_i),
    .want_o     (want)
  );

  assign any_drop = |(gate_q & ~want);
  assign any_add  = |(want & ~gate_q);
  assign reload   = !en_i || any_drop;

  hbg_deadtime #(.DT_CYC(DT_CYC)) u_deadtime (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload),
    .ready_o  (dt_ready)
  );

  always_comb begin
    gate_nx = gate_q;
    if (!en_i)                   gate_nx = '0;
    else if (any_drop)           gate_nx = gate_q & want;
    else if (any_add && dt_ready) gate_nx = want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else        gate_q <= gate_nx;
  end

  assign gate_out = gate_q & {GATES{en_i}};
  assign g_hi1_o  = gate_out[HI1];
  assign g_lo1_o  = gate_out[LO1];
  assign g_hi2_o  = gate_out[HI2];
  assign g_lo2_o  = gate_out[LO2];

  // checker state: edges since the last turn-off or disabled edge
  logic [AW-1:0] quiet_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_age <= '0;
    else if (!en_i || (|(gate_q & ~gate_nx))) quiet_age <= '0;
    else if (quiet_age != AW'(DT_CYC)) quiet_age <= quiet_age + 1'b1;
  end

  // R1
  leg1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_hi1_o && g_lo1_o));
  // R1
  leg2_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(g_hi2_o && g_lo2_o));
  // R2
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_nx & ~gate_q)) |-> (32'(quiet_age) >= DT_CYC - 1));
  // R7
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (gate_out == '0));
  // R9
  phase_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_en_i |=> (gate_q == '0));
  // R4
  fast_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && chop_off_i && !slow_i) |=> !(gate_q[HI1] || gate_q[HI2]));
  // R5
  slow_no_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && chop_off_i && slow_i) |=> !(gate_q[LO1] || gate_q[LO2]));
endmodule

// File: tb/hbridge_gate_seq_bench.sv
`timescale 1ns/1ps
module hbridge_gate_seq_bench;
  localparam int DT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, ph_en = 1'b0, dir = 1'b1, chop = 1'b0, slow = 1'b0;
  logic hi1, lo1, hi2, lo2;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R10";

  always #4 clk = ~clk;

  hbridge_gate_seq #(.DT_CYC(DT)) u_hbridge_gate_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ph_en_i(ph_en), .dir_i(dir),
    .chop_off_i(chop), .slow_i(slow),
    .g_hi1_o(hi1), .g_lo1_o(lo1), .g_hi2_o(hi2), .g_lo2_o(lo2)
  );

  // behavioural model, vector order {hi1,lo1,hi2,lo2}
  logic [3:0] m_gates = 4'b0000;
  int m_age = 0;

  function automatic logic [3:0] wanted(logic pe, logic d, logic c, logic s);
    if (!pe) return 4'b0000;
    if (!c) return d ? 4'b1001 : 4'b0110;
    if (s) return 4'b1010;
    return d ? 4'b0100 : 4'b0001;
  endfunction

  always @(posedge clk) begin
    logic [3:0] w;
    w = wanted(ph_en, dir, chop, slow);
    if (!rst_n || !en) begin
      m_gates = 4'b0000;
      m_age = 0;
    end else if ((m_gates & ~w) != 4'b0000) begin
      m_gates = m_gates & w;
      m_age = 0;
    end else begin
      if (((w & ~m_gates) != 4'b0000) && m_age >= DT - 1) m_gates = w;
      m_age++;
    end
  end

  function automatic logic [3:0] seen();
    return {hi1, lo1, hi2, lo2};
  endfunction

  task automatic check_val(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gates act=%b exp=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, sampled 2 ns after the edge
  always @(posedge clk) begin
    cyc++;
    #2;
    if (!done) begin
      check_val(tag, seen(), en ? m_gates : 4'b0000);
      total++;
      if ((hi1 && lo1) || (hi2 && lo2)) begin
        bad++;
        $display("FAIL R1: leg overlap act=%b exp=no overlap", seen());
      end
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R10";
    run(3);
    check_val("R10 reset", seen(), 4'b0000);
    ph_en = 1'b1; dir = 1'b1;
    rst_n = 1'b1;
    run(DT + 4);
    check_val("R3 dir1 on", seen(), 4'b1001);

    tag = "R4"; chop = 1'b1; slow = 1'b0;
    run(1);
    check_val("R4 fast first edge", seen(), 4'b0000);
    run(DT + 2);
    check_val("R4 fast dir1", seen(), 4'b0100);
    tag = "R6"; chop = 1'b0;
    run(DT + 2);
    check_val("R6 restore fast", seen(), 4'b1001);

    tag = "R5"; chop = 1'b1; slow = 1'b1;
    run(1);
    check_val("R5 slow first edge", seen(), 4'b1000);
    run(DT + 2);
    check_val("R5 slow", seen(), 4'b1010);
    tag = "R6"; chop = 1'b0;
    run(1);
    check_val("R6 slow exit keeps hi1", seen(), 4'b1000);
    run(DT + 2);
    check_val("R6 restore slow", seen(), 4'b1001);

    tag = "R8"; dir = 1'b0;
    run(1);
    check_val("R8 all off", seen(), 4'b0000);
    run(DT + 2);
    check_val("R8 dir0 on", seen(), 4'b0110);
    tag = "R4"; chop = 1'b1; slow = 1'b0;
    run(DT + 3);
    check_val("R4 fast dir0", seen(), 4'b0001);
    tag = "R5"; slow = 1'b1;
    run(DT + 3);
    check_val("R5 slow dir0", seen(), 4'b1010);
    tag = "R6"; chop = 1'b0;
    run(DT + 3);
    check_val("R6 dir0 restore", seen(), 4'b0110);

    tag = "R2"; slow = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chop = 1'b1; run(2);
      chop = 1'b0; run(DT - 3);
    end
    run(DT + 3);
    check_val("R2 short pulses settle", seen(), 4'b0110);

    tag = "R8"; dir = 1'b1; chop = 1'b1; slow = 1'b1;
    run(1);
    check_val("R8 dir+chop same edge", seen(), 4'b0010);
    run(DT + 2);
    check_val("R8 dir+chop settle", seen(), 4'b1010);
    chop = 1'b0;
    run(DT + 3);

    tag = "R9"; ph_en = 1'b0; chop = 1'b1;
    run(2);
    check_val("R9 phase off", seen(), 4'b0000);
    chop = 1'b0; run(3);
    check_val("R9 phase off no chop", seen(), 4'b0000);
    ph_en = 1'b1;
    run(DT + 2);

    tag = "R7"; en = 1'b0;
    #1;
    check_val("R7 immediate off", seen(), 4'b0000);
    run(4);
    en = 1'b1;
    run(1);
    check_val("R7 wait after enable", seen(), 4'b0000);
    run(DT + 2);
    check_val("R7 resumes", seen(), 4'b1001);

    run(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule